// File: doc/BRIEF.md
# Grouped-Priority Interrupt Controller

This block collects level-sensitive interrupt lines, each enabled by its own bit, and presents the winner on one of two request outputs: a high output and a low output. Sources belong to groups of eight. Every group has a priority register with eight ranked positions. Each position holds the 3-bit member code of the group source that sits in it. Position 1 ranks above position 8. Within a group, the first two positions can each be steered to the high output. All other positions always signal the low output.

A configuration register can name one source as the top source. On the output it selects, that source beats everything else. That source also leaves normal group ranking. Each output has a read-only vector register. It shows the winning source number in its top six bits, or 0 when nothing is pending. The vectors are registered and refresh on every clock. Software acknowledges a source by masking it, or by removing its cause.

Top module: `gpic_ctrl`

## Requirements
- R1: After reset, every register reads 0, both request outputs are low and both vectors read 0.
- R2: Word addresses are: 0 configuration, 1 routing, 2 and 3 mask, 4 to 9 group priority for groups 0 to 5, 10 low vector, 11 high vector. The registers at addresses 0 to 9 read back what was last written. Writes to 10 and 11 leave them unchanged.
- R3: Source s (1 to 48) is enabled by bit s mod 32 of the mask register at address 2 + s/32. A source whose bit is 0 is never reported.
- R4: In group g, member code c names source 8g + c + 1. Position p holds its code at bit 32-3p for positions 1 to 3, and at bit 24-3p for positions 4 to 8. A pending source whose code sits in no position is never reported.
- R5: Within a group, the pending enabled source in the lowest-numbered position wins.
- R6: When several groups have a winner for the same output, the lowest-numbered group wins.
- R7: For group g, position p (1 or 2) goes to the high output when routing register bits [4g+2(2-p)+1 : 4g+2(2-p)] hold 2'b01. Any other value sends it low. Positions 3 to 8 always go low.
- R8: Configuration bits [5:0] name the top source (0 means none), and bits [9:8] pick its output (2'b01 high, anything else low). When pending and enabled, it wins its output over all others. It never competes through its group positions.
- R9: A vector reads the source number in bits [31:26] and zeros elsewhere. Its request output is high exactly when that number is nonzero. A change on the inputs or in the registers shows one clock later.
- R10: Inputs are level-sensitive. A source stays reported while its line is high and enabled. It drops out one clock after the line falls or its enable is cleared.
- R11: Configuration bits [21:16] are per-group mode bits. They are stored and read back, and they do not change arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_in | input | 48 | Interrupt levels; bit i is source i+1 |
| irq_lo | output | 1 | Low request output |
| irq_hi | output | 1 | High request output |

## Verification
The hardest case to reach is one source moving between outputs while others stay pending. Examples are the top source stealing a slot-routed source's place on the high output, or a high-routed position falling back to low when its routing field holds a non-01 code. The bench builds these cases with directed register writes. It fills a single group's priority register with distinct codes, sets the routing and top-source fields, and then raises chosen lines together. Each case checks both vectors and both request outputs. Only then does it change one field and check again.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
    localparam int SLOTS    = 8;
    localparam int CODE_W   = 3;
    localparam int DATA_W   = 32;
    localparam int SIG_LSB  = 8;
    localparam int MODE_LSB = 16;
    localparam logic [1:0] SIG_HIGH = 2'b01;

    // Bit offset of the code field for ranked position p (1..8).
    function automatic int slot_lsb(input int p);
        return (p <= 3) ? (32 - 3 * p) : (24 - 3 * p);
    endfunction
endpackage

// File: rtl/gpic_regs.sv
module gpic_regs
    import gpic_pkg::*;
#(
    parameter int GRP_N  = 6,
    parameter int MASK_N = 2,
    parameter int ADDR_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_we,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 cfg_q,
    output logic [DATA_W-1:0]                 route_q,
    output logic [MASK_N-1:0][DATA_W-1:0]     mask_q,
    output logic [GRP_N-1:0][DATA_W-1:0]      prio_q
);
    localparam int A_CFG   = 0;
    localparam int A_ROUTE = 1;
    localparam int A_MASK0 = 2;
    localparam int A_PRIO0 = A_MASK0 + MASK_N;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            route_q <= '0;
            mask_q  <= '0;
            prio_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(A_CFG))   cfg_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(A_ROUTE)) route_q <= bus_wdata;
            for (int m = 0; m < MASK_N; m++)
                if (bus_addr == ADDR_W'(A_MASK0 + m)) mask_q[m] <= bus_wdata;
            for (int g = 0; g < GRP_N; g++)
                if (bus_addr == ADDR_W'(A_PRIO0 + g)) prio_q[g] <= bus_wdata;
        end
    end
endmodule

// File: rtl/gpic_group_arb.sv
module gpic_group_arb
    import gpic_pkg::*;
(
    input  logic [SLOTS-1:0]  pend,
    input  logic [DATA_W-1:0] prio,
    input  logic [3:0]        route,
    output logic              hi_ok,
    output logic [CODE_W-1:0] hi_code,
    output logic              lo_ok,
    output logic [CODE_W-1:0] lo_code
);
    always_comb begin
        hi_ok   = 1'b0;
        hi_code = '0;
        lo_ok   = 1'b0;
        lo_code = '0;
        // Scan from the lowest rank up so the best position is written last.
        for (int p = SLOTS; p >= 1; p--) begin
            logic [CODE_W-1:0] code;
            logic              to_high;
            code    = prio[slot_lsb(p) +: CODE_W];
            to_high = (p <= 2) && (route[(2 - p) * 2 +: 2] == SIG_HIGH);
            if (pend[code]) begin
                if (to_high) begin
                    hi_ok   = 1'b1;
                    hi_code = code;
                end else begin
                    lo_ok   = 1'b1;
                    lo_code = code;
                end
            end
        end
    end
endmodule

// File: rtl/gpic_out_sel.sv
module gpic_out_sel
    import gpic_pkg::*;
#(
    parameter int GRP_N = 6,
    parameter int SRC_W = 6
) (
    input  logic [GRP_N-1:0]             g_hi_ok,
    input  logic [GRP_N-1:0][CODE_W-1:0] g_hi_code,
    input  logic [GRP_N-1:0]             g_lo_ok,
    input  logic [GRP_N-1:0][CODE_W-1:0] g_lo_code,
    input  logic                         top_pend,
    input  logic                         top_high,
    input  logic [SRC_W-1:0]             top_src,
    output logic [SRC_W-1:0]             hi_src,
    output logic [SRC_W-1:0]             lo_src
);
    always_comb begin
        hi_src = '0;
        lo_src = '0;
        // Highest group index first so group 0 has the final say.
        for (int g = GRP_N - 1; g >= 0; g--) begin
            if (g_hi_ok[g])
                hi_src = SRC_W'(g * SLOTS) + SRC_W'(g_hi_code[g]) + SRC_W'(1);
            if (g_lo_ok[g])
                lo_src = SRC_W'(g * SLOTS) + SRC_W'(g_lo_code[g]) + SRC_W'(1);
        end
        if (top_pend) begin
            if (top_high) hi_src = top_src;
            else          lo_src = top_src;
        end
    end
endmodule

// File: rtl/gpic_ctrl.sv
module gpic_ctrl
    import gpic_pkg::*;
#(
    parameter int GRP_N = 6,
    localparam int NUM_SRC = GRP_N * SLOTS,
    localparam int MASK_N  = (NUM_SRC + 1 + DATA_W - 1) / DATA_W,
    localparam int ADDR_W  = $clog2(4 + MASK_N + GRP_N),
    localparam int SRC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               irq_lo,
    output logic               irq_hi
);
    localparam int A_CFG   = 0;
    localparam int A_ROUTE = 1;
    localparam int A_MASK0 = 2;
    localparam int A_PRIO0 = A_MASK0 + MASK_N;
    localparam int A_VLO   = A_PRIO0 + GRP_N;
    localparam int A_VHI   = A_VLO + 1;

    logic [DATA_W-1:0]             cfg_q, route_q;
    logic [MASK_N-1:0][DATA_W-1:0] mask_q;
    logic [GRP_N-1:0][DATA_W-1:0]  prio_q;
    logic [NUM_SRC-1:0]            pend_src, pend_grp;
    logic [SRC_W-1:0]              top_src, top_idx, lo_src, hi_src, lo_vec_q, hi_vec_q;
    logic [1:0]                    top_sig;
    logic                          top_ok, top_pend;
    logic [GRP_N-1:0]              g_hi_ok, g_lo_ok;
    logic [GRP_N-1:0][CODE_W-1:0]  g_hi_code, g_lo_code;

    gpic_regs #(.GRP_N(GRP_N), .MASK_N(MASK_N), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .cfg_q(cfg_q), .route_q(route_q),
        .mask_q(mask_q), .prio_q(prio_q)
    );

    assign top_src = cfg_q[SRC_W-1:0];
    assign top_sig = cfg_q[SIG_LSB +: 2];
    assign top_ok  = (top_src != '0) && (int'(top_src) <= NUM_SRC);
    assign top_idx = top_src - SRC_W'(1);

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            pend_src[i] = irq_in[i] & mask_q[(i + 1) / DATA_W][(i + 1) % DATA_W];
            pend_grp[i] = pend_src[i] & !(top_ok && (int'(top_idx) == i));
        end
        top_pend = top_ok && pend_src[top_idx];
    end

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        gpic_group_arb u_arb (
            .pend(pend_grp[g * SLOTS +: SLOTS]), .prio(prio_q[g]),
            .route(route_q[4 * g +: 4]),
            .hi_ok(g_hi_ok[g]), .hi_code(g_hi_code[g]),
            .lo_ok(g_lo_ok[g]), .lo_code(g_lo_code[g])
        );
    end

    gpic_out_sel #(.GRP_N(GRP_N), .SRC_W(SRC_W)) u_sel (
        .g_hi_ok(g_hi_ok), .g_hi_code(g_hi_code),
        .g_lo_ok(g_lo_ok), .g_lo_code(g_lo_code),
        .top_pend(top_pend), .top_high(top_sig == SIG_HIGH), .top_src(top_src),
        .hi_src(hi_src), .lo_src(lo_src)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_vec_q <= '0;
            hi_vec_q <= '0;
        end else begin
            lo_vec_q <= lo_src;
            hi_vec_q <= hi_src;
        end
    end

    assign irq_lo = (lo_vec_q != '0);
    assign irq_hi = (hi_vec_q != '0);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CFG))   bus_rdata = cfg_q;
        if (bus_addr == ADDR_W'(A_ROUTE)) bus_rdata = route_q;
        for (int m = 0; m < MASK_N; m++)
            if (bus_addr == ADDR_W'(A_MASK0 + m)) bus_rdata = mask_q[m];
        for (int g = 0; g < GRP_N; g++)
            if (bus_addr == ADDR_W'(A_PRIO0 + g)) bus_rdata = prio_q[g];
        if (bus_addr == ADDR_W'(A_VLO)) bus_rdata = {lo_vec_q, {(DATA_W - SRC_W){1'b0}}};
        if (bus_addr == ADDR_W'(A_VHI)) bus_rdata = {hi_vec_q, {(DATA_W - SRC_W){1'b0}}};
    end
endmodule

// File: rtl/gpic_checker.sv
module gpic_checker
    import gpic_pkg::*;
#(
    parameter int GRP_N = 6,
    localparam int NUM_SRC = GRP_N * SLOTS,
    localparam int MASK_N  = (NUM_SRC + 1 + DATA_W - 1) / DATA_W,
    localparam int ADDR_W  = $clog2(4 + MASK_N + GRP_N),
    localparam int SRC_W   = $clog2(NUM_SRC + 1),
    localparam int A_VLO   = 2 + MASK_N + GRP_N
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] pend_src,
    input logic [SRC_W-1:0]   top_src,
    input logic [1:0]         top_sig,
    input logic [SRC_W-1:0]   lo_vec,
    input logic [SRC_W-1:0]   hi_vec,
    input logic               irq_lo,
    input logic               irq_hi,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_rdata
);
    logic [NUM_SRC:0] pend_ext, pend_q;
    logic             top_hi_q, top_lo_q;
    logic [SRC_W-1:0] top_q;

    assign pend_ext = {pend_src, 1'b0};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= '0;
            top_hi_q <= 1'b0;
            top_lo_q <= 1'b0;
            top_q    <= '0;
        end else begin
            pend_q   <= pend_ext;
            top_q    <= top_src;
            top_hi_q <= (top_src != '0) && (int'(top_src) <= NUM_SRC) &&
                        pend_ext[top_src] && (top_sig == SIG_HIGH);
            top_lo_q <= (top_src != '0) && (int'(top_src) <= NUM_SRC) &&
                        pend_ext[top_src] && (top_sig != SIG_HIGH);
        end
    end

    // R3 / R10: a reported source was pending and enabled one cycle earlier.
    p_lo_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_vec != '0) |-> pend_q[lo_vec]);
    p_hi_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_vec != '0) |-> pend_q[hi_vec]);
    // R9: nothing pending means no request.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (!irq_lo && !irq_hi));
    // R8: the top source wins its chosen output.
    p_top_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        top_hi_q |-> (hi_vec == top_q));
    p_top_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        top_lo_q |-> (lo_vec == top_q));
    // R7: one source never shows on both outputs.
    p_one_output_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_vec != '0) |-> (hi_vec != lo_vec));
    // R9: vector readback format.
    p_vec_format_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(A_VLO)) |-> (bus_rdata == {lo_vec, {(DATA_W - SRC_W){1'b0}}}));
endmodule

bind gpic_ctrl gpic_checker #(.GRP_N(GRP_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .pend_src(pend_src),
    .top_src(cfg_q[SRC_W-1:0]), .top_sig(cfg_q[gpic_pkg::SIG_LSB +: 2]),
    .lo_vec(lo_vec_q), .hi_vec(hi_vec_q), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/gpic_ctrl_bench.sv
`timescale 1ns/1ps
module gpic_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [47:0] irq_in = '0;
    logic        irq_lo, irq_hi;
    int          n_run = 0;
    int          n_fail = 0;

    gpic_ctrl u_gpic_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a); bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic set_irq(input logic [47:0] v);
        @(negedge clk);
        irq_in = v;
        settle();
    endtask

    function automatic logic [31:0] fld(input int p, input int code);
        return 32'(code) << ((p <= 3) ? (32 - 3 * p) : (24 - 3 * p));
    endfunction

    task automatic chk_vec(input string tag, input int lo, input int hi);
        logic [31:0] d;
        chk({tag, " irq_lo"}, 32'(irq_lo), 32'(lo != 0));
        chk({tag, " irq_hi"}, 32'(irq_hi), 32'(hi != 0));
        rd(10, d); chk({tag, " lo vector"}, d, 32'(lo) << 26);
        rd(11, d); chk({tag, " hi vector"}, d, 32'(hi) << 26);
    endtask

    task automatic clean();
        @(negedge clk); irq_in = '0;
        for (int a = 0; a < 10; a++) wr(a, 32'h0);
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 12; a++) begin
            rd(a, d); chk("R1 reset register", d, 32'h0);
        end
        chk_vec("R1 reset", 0, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        for (int a = 0; a < 10; a++) wr(a, 32'h5A00_0000 | 32'(a * 3 + 1) << 10);
        for (int a = 0; a < 10; a++) begin
            rd(a, d); chk("R2 readback", d, 32'h5A00_0000 | 32'(a * 3 + 1) << 10);
        end
        clean();
        wr(10, 32'hFFFF_FFFF); wr(11, 32'hFFFF_FFFF);
        settle();
        chk_vec("R2 vector write ignored", 0, 0);
    endtask

    task automatic t_mask();
        wr(4, fld(1, 2));                 // group 0 position 1 -> source 3
        set_irq(48'h4);                   // source 3 line
        chk_vec("R3 masked source", 0, 0);
        wr(2, 32'h8); settle();
        chk_vec("R9 enabled source 3", 3, 0);
        wr(2, 32'h0); settle();
        chk_vec("R10 mask clears", 0, 0);
        wr(2, 32'h8); settle();
        set_irq(48'h0);
        chk_vec("R10 line low clears", 0, 0);
        clean();
    endtask

    task automatic t_order();
        wr(4, fld(1, 5) | fld(4, 1) | fld(8, 7));  // sources 6, 2, 8
        wr(2, 32'h0000_0154);                      // enable 2, 4, 6, 8
        set_irq(48'h08);                           // source 4 only, in no position
        chk_vec("R4 unplaced code", 0, 0);
        set_irq(48'h82);                           // sources 2 and 8
        chk_vec("R5 position 4 beats 8", 2, 0);
        set_irq(48'hA2);                           // add source 6
        chk_vec("R5 position 1 wins", 6, 0);
        clean();
    endtask

    task automatic t_groups();
        wr(2, 32'h0002_0000); wr(3, 32'h2);        // sources 17 and 33
        set_irq((48'h1 << 16) | (48'h1 << 32));
        chk_vec("R6 group 2 before 4", 17, 0);
        set_irq(48'h1 << 32);
        chk_vec("R6 group 4 alone", 33, 0);
        clean();
    endtask

    task automatic t_route();
        wr(5, fld(1, 4) | fld(2, 6) | fld(3, 2));  // sources 13, 15, 11
        wr(2, 32'h0000_A800);                      // enable 11, 13, 15
        wr(1, 32'h40);
        set_irq((48'h1 << 12) | (48'h1 << 10));
        chk_vec("R7 pos1 high pos3 low", 11, 13);
        wr(1, 32'h50);
        set_irq(48'h1 << 14);
        chk_vec("R7 pos2 routed high", 0, 15);
        set_irq(48'h1 << 10);
        chk_vec("R7 pos3 stays low", 11, 0);
        wr(1, 32'h80);
        set_irq(48'h1 << 12);
        chk_vec("R7 code 10 means low", 13, 0);
        clean();
    endtask

    task automatic t_top();
        wr(5, fld(1, 4) | fld(3, 2));              // 13 ranks above 11
        wr(2, 32'h0000_2800);
        wr(0, 32'd11 | (32'h1 << 8));
        set_irq((48'h1 << 12) | (48'h1 << 10));
        chk_vec("R8 top source on high", 13, 11);
        wr(0, 32'd11); settle();
        chk_vec("R8 top source beats position 1", 11, 0);
        wr(2, 32'h0000_2000); settle();
        chk_vec("R8 masked top source", 13, 0);
        clean();
    endtask

    task automatic t_mode();
        logic [31:0] d;
        wr(0, 32'h003F_0000);
        wr(2, 32'h0002_0000); wr(3, 32'h2);
        set_irq((48'h1 << 16) | (48'h1 << 32));
        chk_vec("R11 mode bits no effect", 17, 0);
        rd(0, d); chk("R11 mode readback", d, 32'h003F_0000);
        clean();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #500_000;
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle();
        t_reset();
        t_regs();
        t_mask();
        t_order();
        t_groups();
        t_route();
        t_top();
        t_mode();
        finish_run();
    end
endmodule